// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This execution unit moves the bits of a 32-bit operand by a variable distance and reports the new carry flag. It offers three shifts and four rotates. The shifts are logical left, logical right and arithmetic right. The rotates go left or right, each either in a plain 32-bit ring or in a 33-bit ring that includes the carry. Every bit pushed out of the operand goes through the carry. After a multi-bit move, the carry therefore holds the last bit that left, and any earlier bits are gone.

The distance comes from one of two sources. The first is a small immediate field. The second is the low six bits of a register value. The unit has one register stage. A `start` pulse samples all inputs. On the next cycle `done` is high for one cycle, and the result, carry, zero flag and negative flag are valid. These outputs then hold until the next `start`. A new operation may begin in every cycle.

Top module: `shift_rot_unit`

## Requirements
- R1: `done` is high for exactly the cycle after each cycle in which `start` is sampled high, and low otherwise. Without `start`, `result` and `carry_out` keep their values.
- R2: If `use_imm`=1, the distance is `imm_cnt`. If `use_imm`=0, the distance is `reg_cnt[5:0]`. The upper bits of `reg_cnt` have no effect.
- R3: A distance of 0 returns the operand unchanged, with `carry_out` equal to `carry_in`, for every operation code.
- R4: Code 0, logical left. Zeros enter at bit 0. The carry is the last bit shifted out of bit 31. A distance of 32 gives 0 with carry equal to operand bit 0. Above 32, the result and the carry are both 0.
- R5: Code 1, logical right. Zeros enter at bit 31. The carry is the last bit shifted out of bit 0. Above 32, the result and the carry are both 0.
- R6: Code 2, arithmetic right. Copies of bit 31 enter at the top. The carry is the last bit out of bit 0. At 32 or more, the result is all sign bits and the carry is the sign bit.
- R7: Codes 3 and 4 rotate left and right in a 32-bit ring. The distance is taken modulo 32. The carry is a copy of the last bit that wrapped, which is result bit 0 for a left rotate and result bit 31 for a right rotate.
- R8: Codes 5 and 6 rotate left and right through carry. They use the 33-bit ring {carry, operand}, and the distance is taken modulo 33. A distance of 33 gives back the operand and the carry.
- R9: Code 7 passes the operand through and leaves the carry unchanged.
- R10: `zero` is 1 exactly when `result` is 0. `neg` equals `result[31]`.
- R11: After reset, `done`=0, `result`=0, `carry_out`=0, `zero`=1 and `neg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample inputs and begin an operation |
| op | input | 3 | Operation code (0..7) |
| use_imm | input | 1 | 1: distance from `imm_cnt`, 0: from `reg_cnt` |
| imm_cnt | input | 6 | Immediate distance |
| reg_cnt | input | 32 | Register-supplied distance (low 6 bits used) |
| operand | input | 32 | Value to shift or rotate |
| carry_in | input | 1 | Incoming carry flag |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 32 | Shifted or rotated value |
| carry_out | output | 1 | New carry flag |
| zero | output | 1 | Result is zero |
| neg | output | 1 | Result bit 31 |

## Verification
The bench builds the unit with its default 32-bit width, so the six-bit distance reaches 63. That range covers every boundary: distance 0, 1, 31, 32 where a shift empties the word, 33 where the carry ring closes, and the values just past each. A bit-serial model steps the operand one position at a time. Every operation code is swept against these distances, with both carry values and with operands that have the sign bit set and clear. Register-sourced distances are given noisy upper bits.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                op,
  input  logic                      use_imm,
  input  logic [$clog2(W):0]        imm_cnt,
  input  logic [W-1:0]              reg_cnt,
  input  logic [W-1:0]              operand,
  input  logic                      carry_in,
  output logic                      done,
  output logic [W-1:0]              result,
  output logic                      carry_out,
  output logic                      zero,
  output logic                      neg
);
  localparam int CW = $clog2(W) + 1;
  localparam int RW = W + 1;

  localparam logic [2:0] OP_SHL = 3'd0;
  localparam logic [2:0] OP_SHR = 3'd1;
  localparam logic [2:0] OP_SAR = 3'd2;
  localparam logic [2:0] OP_ROL = 3'd3;
  localparam logic [2:0] OP_ROR = 3'd4;
  localparam logic [2:0] OP_RCL = 3'd5;
  localparam logic [2:0] OP_RCR = 3'd6;

  logic [CW-1:0] n;
  assign n = use_imm ? imm_cnt : reg_cnt[CW-1:0];

  logic [3*W-1:0]        w_shl, w_shr;
  logic signed [3*W-1:0] w_sar;
  assign w_shl = {{(2*W){1'b0}}, operand} << n;
  assign w_shr = {operand, {(2*W){1'b0}}} >> n;
  assign w_sar = $signed({operand, {(2*W){1'b0}}}) >>> n;

  logic [CW-2:0]  r;
  logic [2*W-1:0] d_rol, d_ror;
  assign r     = n[CW-2:0];
  assign d_rol = {operand, operand} << r;
  assign d_ror = {operand, operand} >> r;

  logic [CW-1:0]   k;
  logic [RW-1:0]   ring;
  logic [2*RW-1:0] d_rcl, d_rcr;
  assign k     = (n >= CW'(RW)) ? n - CW'(RW) : n;
  assign ring  = {carry_in, operand};
  assign d_rcl = {ring, ring} << k;
  assign d_rcr = {ring, ring} >> k;

  logic [W-1:0] nx_res;
  logic         nx_c;
  always_comb begin
    nx_res = operand;
    nx_c   = carry_in;
    if (n != '0) begin
      case (op)
        OP_SHL: begin nx_res = w_shl[W-1:0];       nx_c = w_shl[W];     end
        OP_SHR: begin nx_res = w_shr[3*W-1:2*W];   nx_c = w_shr[2*W-1]; end
        OP_SAR: begin nx_res = w_sar[3*W-1:2*W];   nx_c = w_sar[2*W-1]; end
        OP_ROL: begin nx_res = d_rol[2*W-1:W];     nx_c = d_rol[W];     end
        OP_ROR: begin nx_res = d_ror[W-1:0];       nx_c = d_ror[W-1];   end
        OP_RCL: begin nx_res = d_rcl[2*RW-2:RW];   nx_c = d_rcl[2*RW-1]; end
        OP_RCR: begin nx_res = d_rcr[W-1:0];       nx_c = d_rcr[W];     end
        default: begin nx_res = operand;           nx_c = carry_in;     end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result    <= nx_res;
        carry_out <= nx_c;
      end
    end
  end

  assign zero = ~|result;
  assign neg  = result[W-1];

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(carry_out))); // R1
  AST_ZERO_DIST: assert property (@(posedge clk) disable iff (!rst_n)
    (start && n == '0) |=> (result == $past(operand) && carry_out == $past(carry_in))); // R3
  AST_SHL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SHL && n > CW'(W)) |=> (result == '0 && !carry_out)); // R4
  AST_SAR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SAR && n >= CW'(W)) |=>
      (result == {W{$past(operand[W-1])}} && carry_out == $past(operand[W-1]))); // R6
  AST_RCL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_RCL && n == CW'(RW)) |=>
      (result == $past(operand) && carry_out == $past(carry_in))); // R8
  AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd7) |=> (result == $past(operand) && carry_out == $past(carry_in))); // R9
  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_ROL && n != '0) |=> (carry_out == result[0])); // R7
endmodule

// File: tb/shift_rot_unit_test.sv
`timescale 1ns/1ps
module shift_rot_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, use_imm = 1'b1, carry_in = 1'b0;
  logic [2:0] op = '0;
  logic [5:0] imm_cnt = '0;
  logic [31:0] reg_cnt = '0, operand = '0;
  logic done, carry_out, zero, neg;
  logic [31:0] result;

  int checks = 0, errors = 0;

  typedef struct {
    logic [31:0] res;
    logic        c;
    string       tag;
  } exp_t;
  exp_t sb[$];

  shift_rot_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_imm(use_imm),
    .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .operand(operand), .carry_in(carry_in),
    .done(done), .result(result), .carry_out(carry_out), .zero(zero), .neg(neg));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] o, input int n, input logic [31:0] v, input logic c);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      logic t;
      case (o)
        3'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
        3'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
        3'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
        3'd3: begin c = v[31]; v = {v[30:0], v[31]}; end
        3'd4: begin c = v[0];  v = {v[0], v[31:1]}; end
        3'd5: begin t = v[31]; v = {v[30:0], c}; c = t; end
        3'd6: begin t = v[0];  v = {c, v[31:1]}; c = t; end
        default: ;
      endcase
    end
    e.res = v; e.c = c;
    if (n == 0) e.tag = "R3";
    else case (o)
      3'd0: e.tag = "R4";
      3'd1: e.tag = "R5";
      3'd2: e.tag = "R6";
      3'd3, 3'd4: e.tag = "R7";
      3'd5, 3'd6: e.tag = "R8";
      default: e.tag = "R9";
    endcase
    return e;
  endfunction

  task automatic issue(input logic [2:0] o, input int n, input logic [31:0] v, input logic c,
                       input bit imm, input logic [31:0] noise);
    exp_t e;
    @(negedge clk);
    op = o; operand = v; carry_in = c; use_imm = imm;
    imm_cnt = imm ? 6'(n) : 6'(~n);
    reg_cnt = imm ? noise : {noise[31:6], 6'(n)};
    start = 1'b1;
    e = model(o, n, v, c);
    if (!imm) e.tag = {"R2/", e.tag};
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R1 unexpected done", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(result === e.res, e.tag, result, e.res);
          chk(carry_out === e.c, {e.tag, " carry"}, 32'(carry_out), 32'(e.c));
          chk(zero === (e.res == 0) && neg === e.res[31], "R10 flags",
              {30'd0, zero, neg}, {30'd0, e.res == 0, e.res[31]});
        end
      end
    end
  end

  initial begin
    int ns[10] = '{0, 1, 4, 17, 31, 32, 33, 34, 40, 63};
    logic [31:0] vals[3] = '{32'h8000_0001, 32'h5A3C_0F96, 32'hF00D_BEEF};
    logic [31:0] held_r;
    logic held_c;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && result === 32'd0 && carry_out === 1'b0 && zero === 1'b1 && neg === 1'b0,
        "R11 reset", {result[31:4], done, carry_out, zero, neg}, 32'h2);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 10; i++)
        for (int v = 0; v < 3; v++)
          for (int c = 0; c < 2; c++)
            issue(3'(o), ns[i], vals[v], 1'(c), 1'b1, 32'h0);
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 10; i++)
        issue(3'(o), ns[i], vals[i % 3], 1'(i & 1), 1'b0, 32'hDEAD_BE40 ^ 32'(o << 12));
    issue(3'd1, 32, 32'h0000_0000, 1'b1, 1'b1, 32'h0);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    held_r = result; held_c = carry_out;
    operand = 32'h1234_5678; carry_in = ~held_c; op = 3'd3; imm_cnt = 6'd5;
    repeat (3) begin
      @(negedge clk);
      chk(done === 1'b0 && result === held_r && carry_out === held_c, "R1 hold while idle",
          result, held_r);
    end
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R1 all results delivered", 32'(sb.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule